// File: doc/BRIEF.md
# Programmable Time Base Generator

This block turns a chosen clock source into a stream of periodic time-out events. A two-bit source field picks the stepping rate: every system clock, one system clock in four (from a small internal divider), or the pulses of a slow sub-clock. The sub-clock arrives as a clock-enable input that is synchronous to the system clock. The selected steps advance a free-running 15-bit counter. A three-bit period field names one power-of-two tap of that counter, so a time-out happens every 2^(8+N) steps.

Each time-out gives a one-cycle pulse and sets a sticky request flag. That flag is what an interrupt controller watches, and it stays up until a clear input drops it. An enable input drives a two-state controller with the states TB_IDLE and TB_RUN. The transition TB_IDLE→TB_RUN is taken when enable is sampled high. TB_RUN→TB_IDLE is taken when enable is sampled low. Both states hold when enable is unchanged. In TB_IDLE the counter and the divider are held at zero.

Top module: `tbase_gen`

## Requirements
- R1: Source field encoding: 00 steps on every clock, 01 steps once every four clocks, 10 steps on each cycle with `sub_ce` high, and 11 behaves exactly like 00.
- R2: With period field N (0..7), consecutive time-outs are exactly 2^(8+N) selected steps apart.
- R3: Raising `en` gives the first `tick_o` pulse exactly 2^(8+N) steps after the controller enters TB_RUN. For source 00, `tick_o` is first seen high P+1 clock cycles after `en` is driven high, where P = 2^(8+N). For source 01 the same formula applies with P = 4·2^(8+N).
- R4: While `en` is low, no time-out is produced. A low `en` that is sampled for even one clock clears the count, so the next period after re-enabling is a full one.
- R5: A change of the period field while running takes effect at the next wrap of the newly selected tap. No pulse appears before that wrap.
- R6: `tick_o` is high for exactly one clock per time-out.
- R7: `req_o` rises together with `tick_o` and stays high until `clr` is sampled high. It is then low after that edge.
- R8: When a time-out and `clr` fall in the same cycle, `req_o` ends up set.
- R9: After reset, `tick_o` and `req_o` are low and the controller is in TB_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Time base enable |
| src_sel | input | 2 | Step source select |
| period_sel | input | 3 | Tap select N, period 2^(8+N) steps |
| sub_ce | input | 1 | Sub-clock step enable, one cycle per sub-clock tick |
| clr | input | 1 | Clears the request flag |
| tick_o | output | 1 | One-cycle time-out pulse |
| req_o | output | 1 | Sticky time-out request flag |

## Verification
A counter or divider that fails to clear in TB_IDLE shows up as a short first period after re-enabling. The bench catches this within one period by timing the first pulse against the P+1 figure. A wrong tap or a wrong source decode changes the spacing of `tick_o`, so measuring the interval between two consecutive pulses exposes it within two periods. Errors in the flag's state appear at the very next time-out or clear. Three cases cover them: `req_o` seen low while a pulse is seen, `req_o` dropping without a clear, or `req_o` staying high after one.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
    typedef enum logic [1:0] {
        SRC_SYS  = 2'b00,
        SRC_DIV4 = 2'b01,
        SRC_SUB  = 2'b10,
        SRC_ALT  = 2'b11
    } tb_src_e;

    typedef enum logic {
        TB_IDLE = 1'b0,
        TB_RUN  = 1'b1
    } tb_state_e;
endpackage

// File: rtl/tbase_clksel.sv
module tbase_clksel #(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] src_sel,
    input  logic       sub_ce,
    output logic       step
);
    import tbase_pkg::*;
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] DLAST = DW'(DIV - 1);

    logic [DW-1:0] div_q;
    logic          div_step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              div_q <= '0;
        else if (!run)           div_q <= '0;
        else if (div_q == DLAST) div_q <= '0;
        else                     div_q <= div_q + 1'b1;
    end

    assign div_step = (div_q == DLAST);

    always_comb begin
        unique case (tb_src_e'(src_sel))
            SRC_SYS:  step = run;
            SRC_DIV4: step = run & div_step;
            SRC_SUB:  step = run & sub_ce;
            SRC_ALT:  step = run;
            default:  step = run;
        endcase
    end
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
    parameter int BASE = 8,
    parameter int SELW = 3,
    localparam int TAPS = 2 ** SELW,
    localparam int CW   = BASE + TAPS - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            step,
    input  logic [SELW-1:0] period_sel,
    output logic            wrap
);
    logic [CW-1:0]   cnt_q;
    logic [TAPS-1:0] tap_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (!run) cnt_q <= '0;
        else if (step) cnt_q <= cnt_q + 1'b1;
    end

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        assign tap_full[t] = &cnt_q[BASE+t-1:0];
    end

    assign wrap = step & tap_full[period_sel];
endmodule

// File: rtl/tbase_flag.sv
module tbase_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic pulse,
    output logic req
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse <= 1'b0;
            req   <= 1'b0;
        end else begin
            pulse <= set;
            req   <= set | (req & ~clr);
        end
    end
endmodule

// File: rtl/tbase_gen.sv
module tbase_gen #(
    parameter int BASE = 8,
    parameter int SELW = 3,
    parameter int DIV  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [1:0]      src_sel,
    input  logic [SELW-1:0] period_sel,
    input  logic            sub_ce,
    input  logic            clr,
    output logic            tick_o,
    output logic            req_o
);
    import tbase_pkg::*;

    tb_state_e st_q, st_nxt;
    logic      run, step, wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TB_IDLE;
        else        st_q <= st_nxt;
    end

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            TB_IDLE: if (en)  st_nxt = TB_RUN;
            TB_RUN:  if (!en) st_nxt = TB_IDLE;
            default: st_nxt = TB_IDLE;
        endcase
    end

    always_comb begin
        run = 1'b0;
        unique case (st_q)
            TB_IDLE: run = 1'b0;
            TB_RUN:  run = 1'b1;
            default: run = 1'b0;
        endcase
    end

    tbase_clksel #(.DIV(DIV)) clksel_i (
        .clk(clk), .rst_n(rst_n), .run(run),
        .src_sel(src_sel), .sub_ce(sub_ce), .step(step)
    );

    tbase_counter #(.BASE(BASE), .SELW(SELW)) counter_i (
        .clk(clk), .rst_n(rst_n), .run(run), .step(step),
        .period_sel(period_sel), .wrap(wrap)
    );

    tbase_flag flag_i (
        .clk(clk), .rst_n(rst_n), .set(wrap), .clr(clr),
        .pulse(tick_o), .req(req_o)
    );
endmodule

// File: rtl/tbase_gen_chk.sv
module tbase_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic clr,
    input logic tick_o,
    input logic req_o
);
    a_r4_no_tick_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(en) && !$past(en, 2)) |-> !tick_o);

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> req_o);

    a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !clr) |=> req_o);

    a_r7_fall_needs_clr: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_o) |-> $past(clr));
endmodule

bind tbase_gen tbase_gen_chk chk_i (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(clr),
    .tick_o(tick_o), .req_o(req_o)
);

// File: tb/tbase_gen_tb_top.sv
module tbase_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] src_sel = 2'b00;
    logic [2:0] period_sel = 3'd0;
    logic       sub_ce = 1'b0;
    logic       clr = 1'b0;
    logic       tick_o, req_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int sub_ph = 0;

    // src[23:22] per[21:19] latency_check[18] interval_in_clocks[17:0]
    localparam logic [23:0] VECS [8] = '{
        {2'b00, 3'd0, 1'b1, 18'd256},
        {2'b00, 3'd3, 1'b1, 18'd2048},
        {2'b00, 3'd5, 1'b1, 18'd8192},
        {2'b01, 3'd0, 1'b1, 18'd1024},
        {2'b01, 3'd2, 1'b1, 18'd4096},
        {2'b10, 3'd0, 1'b0, 18'd768},
        {2'b10, 3'd1, 1'b0, 18'd1536},
        {2'b11, 3'd1, 1'b1, 18'd512}
    };

    tbase_gen dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .src_sel(src_sel),
        .period_sel(period_sel), .sub_ce(sub_ce), .clr(clr),
        .tick_o(tick_o), .req_o(req_o)
    );

    always #4 clk = ~clk;

    always @(negedge clk) begin
        sub_ph <= (sub_ph == 2) ? 0 : sub_ph + 1;
        sub_ce <= (sub_ph == 1);
        cyc    <= cyc + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_tick(output int n, input int limit);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick_o && n < limit);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    initial begin
        wait (cyc > 190000);
        check("watchdog", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        idle(3);
        check("R9 tick at reset", int'(tick_o), 0);
        check("R9 req at reset", int'(req_o), 0);
        rst_n = 1'b1;
        idle(2);
        check("R9 idle after reset", int'(tick_o), 0);

        // Vector walk: R1, R2, R3
        foreach (VECS[v]) begin
            en = 1'b0;
            src_sel = VECS[v][23:22];
            period_sel = VECS[v][21:19];
            idle(3);
            clr = 1'b1;
            @(negedge clk);
            clr = 1'b0;
            en = 1'b1;
            wait_tick(n, 40000);
            if (VECS[v][18]) check("R3 first timeout latency", n, int'(VECS[v][17:0]) + 1);
            wait_tick(n, 40000);
            check("R1 R2 timeout interval", n, int'(VECS[v][17:0]));
            check("R7 request raised", int'(req_o), 1);
            @(negedge clk);
            check("R6 pulse width one", int'(tick_o), 0);
        end

        // R3 largest tap, latency only
        en = 1'b0; src_sel = 2'b00; period_sel = 3'd7;
        idle(3);
        en = 1'b1;
        wait_tick(n, 40000);
        check("R3 tap 15 latency", n, 32769);

        // R4 disabled: no timeout
        en = 1'b0; period_sel = 3'd0;
        wait_tick(n, 600);
        check("R4 no tick while disabled", int'(tick_o), 0);

        // R4 one-cycle disable mid period restarts full period
        en = 1'b1;
        idle(200);
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        wait_tick(n, 40000);
        check("R4 full period after re-enable", n, 257);

        // R5 period change mid-run
        period_sel = 3'd1;
        wait_tick(n, 40000);
        idle(100);
        period_sel = 3'd0;
        wait_tick(n, 40000);
        check("R5 new tap wrap", n, 156);

        // R7 hold and clear
        clr = 1'b0;
        idle(20);
        check("R7 request held", int'(req_o), 1);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check("R7 request cleared", int'(req_o), 0);

        // R8 set wins over clear
        clr = 1'b1;
        wait_tick(n, 40000);
        check("R8 set wins", int'(req_o), 1);
        @(negedge clk);
        check("R8 clear next cycle", int'(req_o), 0);
        clr = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule